// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block sits between the interrupt source side of a chip and one processor. It keeps a 32-bit status word that holds the processor's current priority threshold in the top byte and the number of the source waiting to be taken in the low 24 bits. It also keeps the priority of that waiting source, and a separate priority that software writes to request an inter-processor interrupt. A lower priority value is more urgent. The block drives a level interrupt line to the processor. When it displaces or refuses a source, it emits a one-cycle reject pulse so the source side can hold that source and offer it again. When the processor opens its threshold with nothing waiting, the block emits a resend pulse.

Commands arrive on one strobe, `cmd_valid`, with a 3-bit kind. The block has no back-pressure: it takes one command on every clock where `cmd_valid` is high. All of its effects show on the outputs on the next clock edge. The accept read returns the status word on `acc_word`, qualified by `acc_valid`. Completion writes forward the finished source number on `eoi_src`, qualified by `eoi_valid`.

Top module: `irq_present_unit`

## Requirements
- R1: After reset the line is low, no pulse is active, the threshold and waiting source are 0 and the inter-processor priority is 0xFF, so every delivery is refused until the threshold is raised.
- R2: A delivery (kind 0, source on `cmd_src`, priority on `cmd_prio`) is refused when its priority is greater than or equal to the threshold, or when a source is waiting whose priority is less than or equal to it. A refusal rejects the delivered source and changes no state.
- R3: An accepted delivery rejects any source that was waiting, stores the new source and priority, and raises the line.
- R4: An accept read (kind 3) returns {threshold, waiting source} on `acc_word` with bits 31:24 the threshold, lowers the line, loads the threshold with the waiting priority and clears the waiting source.
- R5: An inter-processor priority write (kind 2, value on `cmd_prio`) stores the value. If the value is below the threshold and no waiting source has priority less than or equal to it, the block rejects any waiting source, loads source number 2 with the written priority and raises the line.
- R6: A threshold write (kind 1, value on `cmd_prio`) that lowers the threshold, while a source is waiting with priority at or above the new value, clears that source, lowers the line and rejects it. Otherwise the line and the waiting source are kept.
- R7: A completion write (kind 4, word on `cmd_word`) forwards bits 23:0 on `eoi_src` with `eoi_valid`, and copies bits 31:24 into the threshold.
- R8: A resend pulses `resend_req`. If the stored inter-processor priority is below the new threshold, the same cycle also loads source 2 with that priority and raises the line.
- R9: A threshold write that does not lower the value resends only when nothing is waiting. A completion write resends only when nothing is waiting.
- R10: Kinds 5 to 7 and cycles without `cmd_valid` change no state and raise no pulse; reject, resend, completion and accept outputs are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per clock |
| cmd_kind | input | 3 | 0 deliver, 1 threshold write, 2 inter-processor priority write, 3 accept, 4 completion |
| cmd_src | input | 24 | Source number of a delivery |
| cmd_prio | input | 8 | Priority of a delivery, or value of a threshold or inter-processor write |
| cmd_word | input | 32 | Status word of a completion write |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse |
| rej_src | output | 24 | Rejected source number |
| resend_req | output | 1 | Resend request pulse to the source side |
| eoi_valid | output | 1 | Completion forward pulse |
| eoi_src | output | 24 | Completed source number |
| acc_valid | output | 1 | Accept read result valid |
| acc_word | output | 32 | Status word returned by the accept read |

## Verification
Directed traffic first walks a fixed story. A delivery refused at the reset threshold checks that the reset state gates all sources. Equal and lower priority deliveries check the `<=` and `>=` boundaries that separate a refusal from a preemption. Inter-processor writes that tie or beat the waiting priority tell the skip path from the displace path. Threshold writes that lower, raise with nothing waiting, and raise with something waiting check that the clear, the resend and the quiet case are kept apart. A long pseudo-random command stream over a narrow priority range then hits ties often, and every output is compared on every clock against a behavioural model.

// File: rtl/ipp_pkg.sv
package ipp_pkg;
  typedef enum logic [2:0] {
    OP_DELIVER  = 3'd0,
    OP_SET_THR  = 3'd1,
    OP_SET_IPI  = 3'd2,
    OP_ACCEPT   = 3'd3,
    OP_COMPLETE = 3'd4
  } ipp_op_e;
endpackage

// File: rtl/ipp_decide.sv
module ipp_decide #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_kind,
  input  logic [SRC_W-1:0]  cmd_src,
  input  logic [PRIO_W-1:0] cmd_prio,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [PRIO_W-1:0] cur_thr,
  input  logic [SRC_W-1:0]  cur_src,
  input  logic [PRIO_W-1:0] cur_pend,
  input  logic [PRIO_W-1:0] cur_ipi,
  input  logic              cur_line,
  output logic [PRIO_W-1:0] nxt_thr,
  output logic [SRC_W-1:0]  nxt_src,
  output logic [PRIO_W-1:0] nxt_pend,
  output logic [PRIO_W-1:0] nxt_ipi,
  output logic              nxt_line,
  output logic              ev_rej,
  output logic [SRC_W-1:0]  ev_rej_src,
  output logic              ev_resend,
  output logic              ev_eoi,
  output logic [SRC_W-1:0]  ev_eoi_src,
  output logic              ev_acc,
  output logic [WORD_W-1:0] ev_acc_word
);
  import ipp_pkg::*;

  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic busy;
  logic want_resend;

  assign busy = (cur_src != '0);

  always_comb begin
    nxt_thr     = cur_thr;
    nxt_src     = cur_src;
    nxt_pend    = cur_pend;
    nxt_ipi     = cur_ipi;
    nxt_line    = cur_line;
    ev_rej      = 1'b0;
    ev_rej_src  = '0;
    ev_eoi      = 1'b0;
    ev_eoi_src  = '0;
    ev_acc      = 1'b0;
    ev_acc_word = '0;
    want_resend = 1'b0;
    if (cmd_valid) begin
      case (cmd_kind)
        OP_DELIVER: begin
          if (cmd_prio >= cur_thr || (busy && cur_pend <= cmd_prio)) begin
            ev_rej     = 1'b1;
            ev_rej_src = cmd_src;
          end else begin
            ev_rej     = busy;
            ev_rej_src = busy ? cur_src : '0;
            nxt_src    = cmd_src;
            nxt_pend   = cmd_prio;
            nxt_line   = 1'b1;
          end
        end
        OP_SET_IPI: begin
          nxt_ipi = cmd_prio;
          if (cmd_prio < cur_thr && !(busy && cur_pend <= cmd_prio)) begin
            ev_rej     = busy;
            ev_rej_src = busy ? cur_src : '0;
            nxt_src    = IPI_NUM;
            nxt_pend   = cmd_prio;
            nxt_line   = 1'b1;
          end
        end
        OP_SET_THR: begin
          nxt_thr = cmd_prio;
          if (cmd_prio < cur_thr) begin
            if (busy && cmd_prio <= cur_pend) begin
              nxt_src    = '0;
              nxt_line   = 1'b0;
              ev_rej     = 1'b1;
              ev_rej_src = cur_src;
            end
          end else begin
            want_resend = !busy;
          end
        end
        OP_ACCEPT: begin
          ev_acc      = 1'b1;
          ev_acc_word = {cur_thr, cur_src};
          nxt_line    = 1'b0;
          nxt_thr     = cur_pend;
          nxt_src     = '0;
        end
        OP_COMPLETE: begin
          ev_eoi      = 1'b1;
          ev_eoi_src  = cmd_word[SRC_W-1:0];
          nxt_thr     = cmd_word[WORD_W-1 -: PRIO_W];
          want_resend = !busy;
        end
        default: ;
      endcase
    end
    // Resend only happens with nothing waiting, so it never displaces.
    ev_resend = want_resend;
    if (want_resend && cur_ipi < nxt_thr) begin
      nxt_src  = IPI_NUM;
      nxt_pend = cur_ipi;
      nxt_line = 1'b1;
    end
  end
endmodule

// File: rtl/ipp_event_regs.sv
module ipp_event_regs #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rej,
  input  logic [SRC_W-1:0]  ev_rej_src,
  input  logic              ev_resend,
  input  logic              ev_eoi,
  input  logic [SRC_W-1:0]  ev_eoi_src,
  input  logic              ev_acc,
  input  logic [WORD_W-1:0] ev_acc_word,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              resend_req,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              acc_valid,
  output logic [WORD_W-1:0] acc_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rej_valid  <= 1'b0;
      rej_src    <= '0;
      resend_req <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_src    <= '0;
      acc_valid  <= 1'b0;
      acc_word   <= '0;
    end else begin
      rej_valid  <= ev_rej;
      rej_src    <= ev_rej_src;
      resend_req <= ev_resend;
      eoi_valid  <= ev_eoi;
      eoi_src    <= ev_eoi_src;
      acc_valid  <= ev_acc;
      acc_word   <= ev_acc_word;
    end
  end
endmodule

// File: rtl/irq_present_unit.sv
module irq_present_unit #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_kind,
  input  logic [SRC_W-1:0]  cmd_src,
  input  logic [PRIO_W-1:0] cmd_prio,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              irq_out,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              resend_req,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              acc_valid,
  output logic [WORD_W-1:0] acc_word
);
  logic [PRIO_W-1:0] thr_q, pend_q, ipi_q;
  logic [SRC_W-1:0]  src_q;
  logic              line_q;
  logic [PRIO_W-1:0] thr_d, pend_d, ipi_d;
  logic [SRC_W-1:0]  src_d;
  logic              line_d;
  logic              e_rej, e_resend, e_eoi, e_acc;
  logic [SRC_W-1:0]  e_rej_src, e_eoi_src;
  logic [WORD_W-1:0] e_acc_word;

  ipp_decide #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_decide (
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_src(cmd_src),
    .cmd_prio(cmd_prio), .cmd_word(cmd_word),
    .cur_thr(thr_q), .cur_src(src_q), .cur_pend(pend_q), .cur_ipi(ipi_q),
    .cur_line(line_q),
    .nxt_thr(thr_d), .nxt_src(src_d), .nxt_pend(pend_d), .nxt_ipi(ipi_d),
    .nxt_line(line_d),
    .ev_rej(e_rej), .ev_rej_src(e_rej_src), .ev_resend(e_resend),
    .ev_eoi(e_eoi), .ev_eoi_src(e_eoi_src),
    .ev_acc(e_acc), .ev_acc_word(e_acc_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q  <= '0;
      src_q  <= '0;
      pend_q <= '0;
      ipi_q  <= '1;
      line_q <= 1'b0;
    end else begin
      thr_q  <= thr_d;
      src_q  <= src_d;
      pend_q <= pend_d;
      ipi_q  <= ipi_d;
      line_q <= line_d;
    end
  end

  assign irq_out = line_q;

  ipp_event_regs #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_events (
    .clk(clk), .rst_n(rst_n),
    .ev_rej(e_rej), .ev_rej_src(e_rej_src), .ev_resend(e_resend),
    .ev_eoi(e_eoi), .ev_eoi_src(e_eoi_src),
    .ev_acc(e_acc), .ev_acc_word(e_acc_word),
    .rej_valid(rej_valid), .rej_src(rej_src), .resend_req(resend_req),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .acc_valid(acc_valid), .acc_word(acc_word)
  );
endmodule

// File: rtl/ipp_checker.sv
module ipp_checker #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_kind,
  input logic [WORD_W-1:0] cmd_word,
  input logic              irq_out,
  input logic              rej_valid,
  input logic              resend_req,
  input logic              eoi_valid,
  input logic [SRC_W-1:0]  eoi_src,
  input logic              acc_valid
);
  AST_ACCEPT_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 3'd3) |=> (acc_valid && !irq_out)); // R4

  AST_COMPLETE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 3'd4) |=> (eoi_valid && eoi_src == $past(cmd_word[SRC_W-1:0]))); // R7

  AST_LINE_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(cmd_valid && cmd_kind != 3'd3 && cmd_kind < 3'd5)); // R3

  AST_RESEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |-> $past(cmd_valid && (cmd_kind == 3'd1 || cmd_kind == 3'd4))); // R9

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_kind < 3'd5) |=> (!rej_valid && !resend_req && !eoi_valid && !acc_valid)); // R10
endmodule

bind irq_present_unit ipp_checker #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .cmd_word(cmd_word), .irq_out(irq_out), .rej_valid(rej_valid),
  .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
  .acc_valid(acc_valid)
);

// File: tb/irq_present_unit_bench.sv
`timescale 1ns/1ps
module irq_present_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_kind = '0;
  logic [23:0] cmd_src = '0;
  logic [7:0]  cmd_prio = '0;
  logic [31:0] cmd_word = '0;
  logic        irq_out, rej_valid, resend_req, eoi_valid, acc_valid;
  logic [23:0] rej_src, eoi_src;
  logic [31:0] acc_word;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  // behavioural reference state
  int m_thr = 0, m_src = 0, m_pend = 0, m_ipi = 255, m_line = 0;
  int x_rej, x_rsrc, x_res, x_eoi, x_esrc, x_acc, x_aword;

  always #2.5 clk = ~clk;

  irq_present_unit u_irq_present_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_src(cmd_src), .cmd_prio(cmd_prio), .cmd_word(cmd_word),
    .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
    .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .acc_valid(acc_valid), .acc_word(acc_word)
  );

  task automatic model_resend();
    x_res = 1;
    if (m_ipi < m_thr) begin
      m_src = 2; m_pend = m_ipi; m_line = 1;
    end
  endtask

  task automatic model_cmd(input int v, input int k, input int s, input int p, input int w);
    int old;
    x_rej = 0; x_rsrc = 0; x_res = 0; x_eoi = 0; x_esrc = 0; x_acc = 0; x_aword = 0;
    if (!v) return;
    case (k)
      0: begin
        if (p >= m_thr || (m_src != 0 && m_pend <= p)) begin
          x_rej = 1; x_rsrc = s;
        end else begin
          if (m_src != 0) begin x_rej = 1; x_rsrc = m_src; end
          m_src = s; m_pend = p; m_line = 1;
        end
      end
      1: begin
        old = m_thr; m_thr = p;
        if (p < old) begin
          if (m_src != 0 && p <= m_pend) begin
            x_rej = 1; x_rsrc = m_src; m_src = 0; m_line = 0;
          end
        end else if (m_src == 0) model_resend();
      end
      2: begin
        m_ipi = p;
        if (p < m_thr) begin
          if (!(m_src != 0 && m_pend <= p)) begin
            if (m_src != 0) begin x_rej = 1; x_rsrc = m_src; end
            m_src = 2; m_pend = p; m_line = 1;
          end
        end
      end
      3: begin
        x_acc = 1; x_aword = (m_thr << 24) | m_src;
        m_line = 0; m_thr = m_pend; m_src = 0;
      end
      4: begin
        x_eoi = 1; x_esrc = w & 32'h00FF_FFFF;
        m_thr = (w >> 24) & 255;
        if (m_src == 0) model_resend();
      end
      default: ;
    endcase
  endtask

  // Drive at a falling edge, compare at the next falling edge.
  task automatic step(input int v, input int k, input int s, input int p, input int w, input string tag);
    bit bad;
    cmd_valid = v[0]; cmd_kind = k[2:0]; cmd_src = s[23:0];
    cmd_prio = p[7:0]; cmd_word = w[31:0];
    model_cmd(v, k, s, p, w);
    @(negedge clk);
    cmd_valid = 1'b0;
    vectors++;
    bad = (irq_out != m_line[0]) || (rej_valid != x_rej[0]) ||
          (x_rej != 0 && rej_src != x_rsrc[23:0]) || (resend_req != x_res[0]) ||
          (eoi_valid != x_eoi[0]) || (x_eoi != 0 && eoi_src != x_esrc[23:0]) ||
          (acc_valid != x_acc[0]) || (x_acc != 0 && acc_word != x_aword[31:0]);
    if (bad) begin
      misses++;
      $display("FAIL %s: irq=%0d/%0d rej=%0d:%0h/%0d:%0h resend=%0d/%0d eoi=%0d:%0h/%0d:%0h acc=%0d:%0h/%0d:%0h (actual/expected)",
               tag, irq_out, m_line, rej_valid, rej_src, x_rej, x_rsrc, resend_req, x_res,
               eoi_valid, eoi_src, x_eoi, x_esrc, acc_valid, acc_word, x_acc, x_aword);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R1");                 // reset state idle
    step(1, 0, 5, 3, 0, "R1");                 // threshold 0 refuses all
    step(1, 4, 0, 0, 32'hFF00_0000, "R7");     // open threshold, resend, ipi FF not below
    step(1, 0, 5, 10, 0, "R3");                // accepted
    step(1, 0, 6, 10, 0, "R2");                // tie with waiting: refused
    step(1, 0, 7, 4, 0, "R3");                 // preempts, rejects 5
    step(1, 3, 0, 0, 0, "R4");                 // returns FF000007, thr=4
    step(1, 0, 8, 4, 0, "R2");                 // equal to threshold: refused
    step(1, 2, 0, 2, 0, "R5");                 // ipi loaded, source 2
    step(1, 2, 0, 3, 0, "R5");                 // waiting 2 <= 3: skip
    step(1, 0, 9, 1, 0, "R3");                 // displaces ipi source 2
    step(1, 1, 0, 1, 0, "R6");                 // lower to 1, pend 1: clear+reject 9
    step(1, 1, 0, 6, 0, "R8");                 // raise, empty: resend + ipi 3
    step(1, 1, 0, 8, 0, "R9");                 // raise, waiting: no resend
    step(1, 7, 11, 0, 32'hFFFF_FFFF, "R10");   // ignored kind
    step(1, 5, 11, 0, 0, "R10");               // ignored kind
    step(1, 3, 0, 0, 0, "R10");                // state intact: returns 08000002
    step(1, 4, 0, 0, 32'h0A00_000C, "R7");     // forward C, thr A, resend ipi 3
    step(1, 1, 0, 5, 0, "R6");                 // lower to 5, pend 3 kept
    step(1, 2, 0, 255, 0, "R5");               // not below: stored only
    step(1, 2, 0, 1, 0, "R5");                 // beats pend 3: reject 2, reload
    step(1, 3, 0, 0, 0, "R4");
    step(1, 4, 0, 0, 32'h0900_0002, "R9");     // empty: resend, ipi 1<9 reloads
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 600; i++) begin
      int k;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      k = int'(lfsr[2:0]);
      step(int'(lfsr[3] | lfsr[4]), k, 1 + int'(lfsr[8:5]), int'(lfsr[12:9]),
           {4'h0, lfsr[16:13], 19'h0, lfsr[21:17]}, "R10");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule